// File: doc/BRIEF.md
# Per-Warp Memory Fence Guard

This block sits beside the issue stage of a streaming multiprocessor and enforces memory ordering one warp at a time. For each warp it counts the global-memory loads and the global-memory stores that have issued and not yet completed, in two separate counters. When a warp issues an access that is a fence point, the warp is held from issuing again until every global access it issued up to and including that point has completed, which means both of its counters are back at zero. Shared-memory accesses are never counted, because they do not need completion tracking.

A mode input picks the ordering model. In relaxed mode only issues marked as synchronization (an explicit fence or a synchronizing access) are fence points. In sequentially consistent mode every shared or global access is also a fence point. The scheduler offers one issue request per cycle (warp, access kind, sync flag) and gets a combinational grant back. The memory side reports one completion per cycle (warp, load or store). A stall vector with one bit per warp tells the scheduler which warps are held.

Each warp slot is a two-state machine. In RUN the warp issues freely. The transition RUN to FENCE_WAIT is taken when a fence point of that warp is granted. The transition FENCE_WAIT to RUN is taken when both counters of the warp are zero. A fence grant in FENCE_WAIT keeps the slot in FENCE_WAIT. The stall bit is high only in FENCE_WAIT while either counter is nonzero, so it drops in the same cycle that the last completion takes effect.

Top module: `warp_fence_guard`

## Requirements
- R1: After reset every counter is zero, no warp is stalled and the error output is low.
- R2: A granted access of kind 2 (global load) increments that warp's load counter and one of kind 3 (global store) increments its store counter. A completion with the store flag low decrements the warp's load counter, and with the flag high it decrements the store counter.
- R3: Kind 1 (shared access) and kind 0 (no memory access) never change either counter.
- R4: In relaxed mode (mode input low) only a granted issue with the sync flag high is a fence point. This includes kind 0 with sync as an explicit fence.
- R5: In sequentially consistent mode (mode input high) every granted issue of kind 1, 2 or 3 is a fence point, as is any issue with the sync flag.
- R6: After a granted fence point, the warp's stall bit is high from the next cycle for as long as either of its counters is nonzero. It falls in the same cycle that both counters reach zero. Other warps are not affected.
- R7: An issue from a stalled warp is refused: the grant is low and no counter or stall state changes.
- R8: Counters are 6 bits wide. A global load is refused while the load counter is at 63, and a global store is refused while the store counter is at 63. The other kind is still granted.
- R9: A granted issue and a completion on the same counter in the same cycle leave that counter unchanged.
- R10: A completion on a counter that is zero sets the error output, which stays high until reset, and the counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_mode | input | 1 | 1 selects sequentially consistent mode, 0 selects relaxed mode |
| iss_valid | input | 1 | Issue request present |
| iss_warp | input | 5 | Warp of the issue request |
| iss_kind | input | 2 | 0 none, 1 shared, 2 global load, 3 global store |
| iss_sync | input | 1 | Issue is a synchronization or explicit fence |
| iss_grant | output | 1 | Issue accepted this cycle |
| cmp_valid | input | 1 | Completion present |
| cmp_warp | input | 5 | Warp of the completion |
| cmp_store | input | 1 | 1 for a store completion, 0 for a load completion |
| warp_stall | output | 32 | One hold bit per warp |
| underflow_err | output | 1 | Sticky flag for a completion with no matching pending access |

## Verification
The assertions check on every cycle that a grant never goes to a stalled warp and only answers a valid request. They also check that a stall bit only rises right after a granted fence point of that warp, that it only falls right after a completion for that warp, and that the error flag never clears by itself. The bench's scenarios are needed to show the counting itself: the exact moment a stall drops after the last of many completions, saturation at 63, same-cycle issue and completion, and the counter staying at zero after an underflow. All of these need knowledge of the counts that is not visible at the ports.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_SHARED = 2'd1,
        K_GLOAD  = 2'd2,
        K_GSTORE = 2'd3
    } acc_kind_t;

    typedef enum logic {
        S_RUN        = 1'b0,
        S_FENCE_WAIT = 1'b1
    } slot_state_t;
endpackage

// File: rtl/wfg_counter.sv
module wfg_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic             zero,
    output logic             full,
    output logic             uflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    assign zero  = (cnt_q == '0);
    assign full  = (cnt_q == CNT_MAX);
    assign uflow = dec && zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && !zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wfg_warp_slot.sv
module wfg_warp_slot
    import wfg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_inc,
    input  logic st_inc,
    input  logic ld_dec,
    input  logic st_dec,
    input  logic fence_set,
    output logic stall,
    output logic ld_full,
    output logic st_full,
    output logic uflow
);
    slot_state_t state_q, state_d;
    logic ld_zero, st_zero, ld_uf, st_uf;

    wfg_counter #(.CNT_W(CNT_W)) u_ld (
        .clk(clk), .rst_n(rst_n), .inc(ld_inc), .dec(ld_dec),
        .zero(ld_zero), .full(ld_full), .uflow(ld_uf)
    );

    wfg_counter #(.CNT_W(CNT_W)) u_st (
        .clk(clk), .rst_n(rst_n), .inc(st_inc), .dec(st_dec),
        .zero(st_zero), .full(st_full), .uflow(st_uf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:        if (fence_set) state_d = S_FENCE_WAIT;
            S_FENCE_WAIT: if (!fence_set && ld_zero && st_zero) state_d = S_RUN;
            default:      state_d = S_RUN;
        endcase
    end

    always_comb begin
        stall = (state_q == S_FENCE_WAIT) && !(ld_zero && st_zero);
        uflow = ld_uf || st_uf;
    end
endmodule

// File: rtl/warp_fence_guard.sv
module warp_fence_guard
    import wfg_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    parameter int CNT_W     = 6,
    parameter int WARP_W    = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sc_mode,
    input  logic                 iss_valid,
    input  logic [WARP_W-1:0]    iss_warp,
    input  logic [1:0]           iss_kind,
    input  logic                 iss_sync,
    output logic                 iss_grant,
    input  logic                 cmp_valid,
    input  logic [WARP_W-1:0]    cmp_warp,
    input  logic                 cmp_store,
    output logic [NUM_WARPS-1:0] warp_stall,
    output logic                 underflow_err
);
    acc_kind_t kind;
    logic [NUM_WARPS-1:0] ld_full, st_full, slot_uf;
    logic is_fence, blocked;

    assign kind = acc_kind_t'(iss_kind);

    always_comb begin
        blocked = warp_stall[iss_warp]
               || (kind == K_GLOAD  && ld_full[iss_warp])
               || (kind == K_GSTORE && st_full[iss_warp]);
        iss_grant = iss_valid && !blocked;
        is_fence  = iss_sync || (sc_mode && kind != K_NONE);
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        logic sel_iss, sel_cmp;
        assign sel_iss = iss_grant && (iss_warp == WARP_W'(w));
        assign sel_cmp = cmp_valid && (cmp_warp == WARP_W'(w));

        wfg_warp_slot #(.CNT_W(CNT_W)) u_slot (
            .clk(clk),
            .rst_n(rst_n),
            .ld_inc(sel_iss && kind == K_GLOAD),
            .st_inc(sel_iss && kind == K_GSTORE),
            .ld_dec(sel_cmp && !cmp_store),
            .st_dec(sel_cmp && cmp_store),
            .fence_set(sel_iss && is_fence),
            .stall(warp_stall[w]),
            .ld_full(ld_full[w]),
            .st_full(st_full[w]),
            .uflow(slot_uf[w])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         underflow_err <= 1'b0;
        else if (|slot_uf)  underflow_err <= 1'b1;
    end
endmodule

// File: rtl/wfg_checker.sv
module wfg_checker #(
    parameter int NUM_WARPS = 32,
    parameter int WARP_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sc_mode,
    input logic                 iss_valid,
    input logic [WARP_W-1:0]    iss_warp,
    input logic [1:0]           iss_kind,
    input logic                 iss_sync,
    input logic                 iss_grant,
    input logic                 cmp_valid,
    input logic [WARP_W-1:0]    cmp_warp,
    input logic                 cmp_store,
    input logic [NUM_WARPS-1:0] warp_stall,
    input logic                 underflow_err
);
    // R7: a held warp is never granted
    a_r7_no_grant_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> !warp_stall[iss_warp]);

    // R7: grant only answers a request
    a_r7_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> iss_valid);

    // R10: the error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        // R6: a stall starts only after a granted fence point of this warp (R4, R5)
        a_r6_stall_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(warp_stall[w]) |-> $past(iss_grant && iss_warp == WARP_W'(w)
                && (iss_sync || (sc_mode && iss_kind != 2'd0))));
        // R6: a stall ends only after a completion for this warp
        a_r6_stall_fall: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(warp_stall[w]) |-> $past(cmp_valid && cmp_warp == WARP_W'(w)));
    end
endmodule

bind warp_fence_guard wfg_checker #(.NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W)) u_wfg_chk (
    .clk(clk), .rst_n(rst_n), .sc_mode(sc_mode), .iss_valid(iss_valid),
    .iss_warp(iss_warp), .iss_kind(iss_kind), .iss_sync(iss_sync),
    .iss_grant(iss_grant), .cmp_valid(cmp_valid), .cmp_warp(cmp_warp),
    .cmp_store(cmp_store), .warp_stall(warp_stall), .underflow_err(underflow_err)
);

// File: tb/test_warp_fence_guard.sv
`timescale 1ns/1ps
module test_warp_fence_guard;
    localparam int NW  = 32;
    localparam int MAX = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sc_mode = 1'b0;
    logic iss_valid = 1'b0;
    logic [4:0] iss_warp = '0;
    logic [1:0] iss_kind = '0;
    logic iss_sync = 1'b0;
    logic iss_grant;
    logic cmp_valid = 1'b0;
    logic [4:0] cmp_warp = '0;
    logic cmp_store = 1'b0;
    logic [NW-1:0] warp_stall;
    logic underflow_err;

    int checks = 0;
    int failures = 0;
    int ld_m [NW];
    int st_m [NW];
    bit wt_m [NW];
    bit err_m = 0;

    always #2.5 clk = ~clk;

    warp_fence_guard i_warp_fence_guard (
        .clk(clk), .rst_n(rst_n), .sc_mode(sc_mode), .iss_valid(iss_valid),
        .iss_warp(iss_warp), .iss_kind(iss_kind), .iss_sync(iss_sync),
        .iss_grant(iss_grant), .cmp_valid(cmp_valid), .cmp_warp(cmp_warp),
        .cmp_store(cmp_store), .warp_stall(warp_stall), .underflow_err(underflow_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] exp_stall();
        logic [NW-1:0] v;
        for (int i = 0; i < NW; i++) v[i] = wt_m[i] && (ld_m[i] != 0 || st_m[i] != 0);
        return v;
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic op(input bit v, input int w, input int k, input bit s,
                      input bit cv, input int cw, input bit cs, input string tag);
        bit eg, fence;
        logic [NW-1:0] es;
        iss_valid = v; iss_warp = 5'(w); iss_kind = 2'(k); iss_sync = s;
        cmp_valid = cv; cmp_warp = 5'(cw); cmp_store = cs;
        #1;
        es = exp_stall();
        eg = v && !es[w] && !(k == 2 && ld_m[w] == MAX) && !(k == 3 && st_m[w] == MAX);
        chk(iss_grant == eg, tag, "grant", 64'(iss_grant), 64'(eg));
        fence = eg && (s || (sc_mode && k != 0));
        for (int i = 0; i < NW; i++) begin
            bit li, si, ldd, sdd;
            if (wt_m[i] && ld_m[i] == 0 && st_m[i] == 0) wt_m[i] = 0;
            li  = eg && i == w && k == 2;
            si  = eg && i == w && k == 3;
            ldd = cv && i == cw && !cs;
            sdd = cv && i == cw && cs;
            if ((ldd && ld_m[i] == 0) || (sdd && st_m[i] == 0)) err_m = 1;
            if (li && !ldd) ld_m[i]++;
            else if (ldd && !li && ld_m[i] > 0) ld_m[i]--;
            if (si && !sdd) st_m[i]++;
            else if (sdd && !si && st_m[i] > 0) st_m[i]--;
        end
        if (fence) wt_m[w] = 1;
        @(posedge clk);
        @(negedge clk);
        iss_valid = 0; cmp_valid = 0;
        #1;
        es = exp_stall();
        chk(warp_stall == es, tag, "stall", 64'(warp_stall), 64'(es));
        chk(underflow_err == err_m, tag, "err", 64'(underflow_err), 64'(err_m));
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NW; i++) begin ld_m[i] = 0; st_m[i] = 0; wt_m[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(warp_stall == '0, "R1", "reset stall", 64'(warp_stall), 64'd0);
        chk(underflow_err == 1'b0, "R1", "reset err", 64'(underflow_err), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R2, R4: relaxed mode, global traffic on every warp without sync
        for (int w = 0; w < NW; w++) begin
            op(1, w, 2, 0, 0, 0, 0, "R2_R4");
            op(1, w, 3, 0, 0, 0, 0, "R2_R4");
        end
        // R3: shared and plain issues in relaxed mode change nothing
        for (int w = 0; w < NW; w += 7) op(1, w, 1, 0, 0, 0, 0, "R3");
        // R4: explicit fence on each warp
        for (int w = 0; w < NW; w++) op(1, w, 0, 1, 0, 0, 0, "R4_R6");
        // R7: a held warp gets no grant
        for (int w = 0; w < NW; w += 5) op(1, w, 2, 0, 0, 0, 0, "R7");
        // R6: drain loads then stores; stall falls on the last completion
        for (int w = 0; w < NW; w++) op(0, 0, 0, 0, 1, w, 0, "R2_R6");
        for (int w = 0; w < NW; w++) op(0, 0, 0, 0, 1, w, 1, "R2_R6");

        // R5: sequentially consistent mode
        sc_mode = 1;
        op(1, 4, 1, 0, 0, 0, 0, "R3_R5");
        op(1, 4, 0, 0, 0, 0, 0, "R5");
        op(1, 4, 2, 0, 0, 0, 0, "R5");
        op(1, 4, 3, 0, 0, 0, 0, "R7");
        op(1, 9, 3, 0, 0, 0, 0, "R5_R6");
        op(0, 0, 0, 0, 1, 4, 0, "R6");
        op(0, 0, 0, 0, 1, 9, 1, "R6");
        op(1, 4, 3, 0, 0, 0, 0, "R5");
        op(0, 0, 0, 0, 1, 4, 1, "R6");
        sc_mode = 0;

        // R8: saturation of warp 5 load counter
        for (int n = 0; n < MAX + 2; n++) op(1, 5, 2, 0, 0, 0, 0, "R8");
        op(1, 5, 3, 0, 0, 0, 0, "R8");
        // R9: issue and completion on the same counter together
        op(1, 5, 2, 0, 1, 5, 0, "R9");
        op(1, 5, 2, 0, 0, 0, 0, "R8_R9");
        op(1, 5, 3, 0, 1, 5, 1, "R9");
        for (int n = 0; n < MAX; n++) op(0, 0, 0, 0, 1, 5, 0, "R2");
        op(0, 0, 0, 0, 1, 5, 1, "R2");

        // R4: relaxed sync load stalls until its completion
        op(1, 12, 2, 1, 0, 0, 0, "R4");
        op(0, 0, 0, 0, 1, 12, 0, "R6");

        // R10: completion on an idle counter, then show it stayed at zero
        op(0, 0, 0, 0, 1, 20, 1, "R10");
        op(1, 20, 3, 1, 0, 0, 0, "R10");
        op(0, 0, 0, 0, 1, 20, 1, "R10");
        op(1, 20, 3, 0, 0, 0, 0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule